// File: doc/BRIEF.md
# Gated Serial-to-Parallel Shift Register

This block collects a serial bit stream into a register of eight stages and exposes every stage at once as a parallel word. On each rising clock edge, the word moves one place toward the high end. The lowest stage takes in a new bit, which is the logical AND of two serial inputs. Holding one input high passes the other input straight through. Holding it low fills the register with zeros. Either input can therefore serve as a data enable for the other.

An active-low clear empties the register at once, with no clock needed, and takes priority over any shift. While the clear is held, clock edges have no effect. Shifting resumes on the first rising edge after the clear is released. The stage count is a parameter, and its default is eight.

Top module: `gated_sipo_reg`

## Requirements
- R1: While `clr_n` is low, every bit of `par_q` is 0. It goes to 0 without waiting for a clock edge.
- R2: `par_q` changes only at a rising edge of `clk` or when `clr_n` falls. Changing `din_a` or `din_b` between edges leaves `par_q` as it is.
- R3: At each rising edge with `clr_n` high, bit k of `par_q` (for k from 1 to STAGES-1) takes the value bit k-1 held just before that edge. The old top bit is dropped.
- R4: At each rising edge with `clr_n` high, bit 0 of `par_q` takes `din_a & din_b` as sampled at that edge.
- R5: If either serial input is 0 at an edge, a 0 is shifted into bit 0, whatever the other input is.
- R6: With `din_b` held at 1, bit 0 follows `din_a` edge by edge, and the same holds with the roles of the two inputs swapped.
- R7: Rising edges that arrive while `clr_n` is low cause no shift. The first shift after release happens on the first rising edge with `clr_n` high.
- R8: A clear applied in the middle of a stream discards all stored bits. This includes a clear that falls at the same instant as a rising clock edge.

Top module parameter: `STAGES` (default 8, at least 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the register advances on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| din_a | input | 1 | First serial input, ANDed with `din_b` |
| din_b | input | 1 | Second serial input, ANDed with `din_a` |
| par_q | output | STAGES | Parallel view of all stages; bit 0 is the newest |

## Verification
The shift properties are switched off while the clear is low. This assumes that every clear pulse stays low across at least one rising clock edge. A shorter clear pulse that falls and rises between two edges would leave a shift comparison spanning the cleared state. The stimulus therefore holds `clr_n` low for at least one full clock period. It changes `clr_n` and the serial inputs on the falling clock edge, with one exception: a single clear is deliberately dropped exactly on a rising edge. The reference model in the bench treats both orderings at that edge as ending in an empty register.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    localparam int unsigned DEF_STAGES = 8;

    // Serial bit entering the chain: either input low forces a zero.
    function automatic logic serial_bit(input logic a, input logic b);
        return a & b;
    endfunction

endpackage

// File: rtl/sipo_gate.sv
module sipo_gate (
    input  logic din_a,
    input  logic din_b,
    output logic ser
);

    always_comb begin
        ser = sipo_pkg::serial_bit(din_a, din_b);
    end

endmodule

// File: rtl/sipo_chain.sv
module sipo_chain #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              ser_in,
    output logic [STAGES-1:0] q
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] stg;
    } chain_t;

    chain_t st_d;
    chain_t st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = ser_in;
        for (int k = 1; k <= int'(LAST); k++) begin
            st_d.stg[k] = st_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.stg;

endmodule

// File: rtl/gated_sipo_reg.sv
module gated_sipo_reg #(
    parameter int unsigned STAGES = sipo_pkg::DEF_STAGES
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              din_a,
    input  logic              din_b,
    output logic [STAGES-1:0] par_q
);

    logic ser_bit;

    sipo_gate u_gate (
        .din_a (din_a),
        .din_b (din_b),
        .ser   (ser_bit)
    );

    sipo_chain #(
        .STAGES (STAGES)
    ) u_chain (
        .clk    (clk),
        .clr_n  (clr_n),
        .ser_in (ser_bit),
        .q      (par_q)
    );

endmodule

// File: rtl/sipo_chk.sv
module sipo_chk #(
    parameter int unsigned STAGES = 8
) (
    input logic              clk,
    input logic              clr_n,
    input logic              din_a,
    input logic              din_b,
    input logic [STAGES-1:0] par_q
);

    // R1 / R7: a clear seen at an edge means an empty register there
    p_clear_empty_r1: assert property (@(posedge clk)
        !clr_n |-> (par_q == '0));

    // R3: every upper stage copies its lower neighbour
    p_shift_up_r3: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> (par_q[STAGES-1:1] == $past(par_q[STAGES-2:0])));

    // R4: stage zero takes the gated serial bit
    p_entry_r4: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> (par_q[0] == $past(din_a & din_b)));

    // R5: a low on either input forces a zero in
    p_gate_a_r5: assert property (@(posedge clk) disable iff (!clr_n)
        !din_a |=> !par_q[0]);
    p_gate_b_r5: assert property (@(posedge clk) disable iff (!clr_n)
        !din_b |=> !par_q[0]);

    // R6: one input held high passes the other
    p_pass_a_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (din_b && din_a) |=> par_q[0]);

endmodule

bind gated_sipo_reg sipo_chk #(
    .STAGES (STAGES)
) u_sipo_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .din_a (din_a),
    .din_b (din_b),
    .par_q (par_q)
);

// File: tb/tb_gated_sipo_reg.sv
`timescale 1ns/1ps
module tb_gated_sipo_reg;

    localparam int unsigned N = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         din_a = 1'b0;
    logic         din_b = 1'b0;
    logic [N-1:0] par_q;

    logic [N-1:0] model = '0;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    gated_sipo_reg #(.STAGES(N)) dut (
        .clk   (clk),
        .clr_n (clr_n),
        .din_a (din_a),
        .din_b (din_b),
        .par_q (par_q)
    );

    always #2.5 clk = ~clk;

    function automatic logic [N-1:0] next_word(input logic [N-1:0] w,
                                               input logic a, input logic b);
        return {w[N-2:0], a & b};
    endfunction

    task automatic check(input string req, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; leaves at the next falling edge
    task automatic step(input string req, input logic a, input logic b);
        din_a = a;
        din_b = b;
        @(posedge clk);
        model = next_word(model, a, b);
        @(negedge clk);
        check(req, par_q, model);
    endtask

    task automatic mid_clear(input string req);
        clr_n = 1'b0;
        model = '0;
        #0.5;
        check(req, par_q, model);
        @(negedge clk);
        check(req, par_q, model);
        clr_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1;
        check("R1 reset state", par_q, '0);

        // R7: edges during clear with ones on both inputs
        din_a = 1'b1;
        din_b = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 no shift while clear", par_q, '0);
        clr_n = 1'b1;
        step("R7 first shift after release", 1'b1, 1'b1);
        check("R7 exactly one bit", par_q, 8'b0000_0001);

        // R5 / R6 / R4 all four input pairs
        step("R5 a=1 b=0 gives zero", 1'b1, 1'b0);
        step("R5 a=0 b=1 gives zero", 1'b0, 1'b1);
        step("R5 a=0 b=0 gives zero", 1'b0, 1'b0);
        step("R4 a=1 b=1 gives one", 1'b1, 1'b1);
        check("R4 pattern", par_q, 8'b0001_0001);

        // R6: b held high passes a; then a held high passes b
        step("R6 b high passes a", 1'b1, 1'b1);
        step("R6 b high passes a", 1'b0, 1'b1);
        step("R6 a high passes b", 1'b1, 1'b0);
        step("R6 a high passes b", 1'b1, 1'b1);

        // R2: inputs change between edges, outputs hold
        din_a = ~din_a;
        din_b = 1'b1;
        #1;
        check("R2 stable between edges", par_q, model);
        din_a = 1'b1;
        #0.5;
        check("R2 stable between edges", par_q, model);

        // R3: walk a single one to the top and out
        mid_clear("R8 clear before walk");
        step("R3 walk load", 1'b1, 1'b1);
        for (int k = 1; k < int'(N); k++) begin
            step("R3 walk", 1'b0, 1'b1);
            check("R3 walk position", par_q, 8'(1) << k);
        end
        step("R3 top bit drops", 1'b0, 1'b0);
        check("R3 empty after walk", par_q, '0);

        // R8: clear falling on a rising edge
        step("R4 refill", 1'b1, 1'b1);
        step("R4 refill", 1'b1, 1'b1);
        @(posedge clk);
        clr_n = 1'b0;
        model = '0;
        @(negedge clk);
        check("R8 clear on clock edge", par_q, '0);
        @(negedge clk);
        check("R8 clear held", par_q, '0);
        clr_n = 1'b1;
        step("R7 resume after edge clear", 1'b1, 1'b1);

        // random stream with occasional mid-stream clears
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 25) == 0) begin
                mid_clear("R8 random mid-stream clear");
            end else begin
                step("R3 R4 random stream", 1'($urandom), 1'($urandom));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run hung actual=%0t expected=done", $time);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule